// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column address presented on every beat of an SDRAM read or write burst. A burst begins when the controller pulses `cmd_start` with a starting column, a burst-length code and an ordering select. Starting on the next cycle, the block steps through the burst one beat per clock. It raises `col_valid` on each beat and `last_beat` on the final beat of a finite burst. Bank and row handling, data movement and command decoding stay in the surrounding controller.

Two orderings are supported. Sequential ordering counts upward and wraps inside the naturally aligned block whose size is the burst length. Interleaved ordering takes the starting column and XORs it with the beat number. A full-page burst counts through all columns of the row, wraps from the top column back to zero, and runs until it is stopped or replaced. `cmd_stop` ends a burst in progress. A new `cmd_start` replaces the burst in progress on any cycle.

The controller is a three-state machine:
- ST_IDLE: no burst in progress.
- ST_BURST: a finite burst is running.
- ST_PAGE: a full-page burst is running.

Transitions:
- idle→burst: start with a finite length code.
- idle→page: start with the full-page code.
- burst→idle: stop, or the final beat.
- page→idle: stop.
- burst/page→burst/page: start, which reloads the burst.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `col_valid` and `last_beat` are 0.
- R2: A start sampled at a clock edge makes `col_valid` 1 from that edge onward, with `col_addr` equal to the sampled start column. Length codes: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats and 7 gives full page.
- R3: With `cmd_intlv`=0 and a finite length L, beat i carries the start column with its low log2(L) bits replaced by (start + i) mod L. The upper bits are unchanged.
- R4: With `cmd_intlv`=1 and a finite length L, beat i carries the start column XOR i.
- R5: A finite burst gives exactly L valid beats. `last_beat` is 1 only on the final beat, and `col_valid` is 0 on the cycle after it unless a new start arrived.
- R6: A full-page burst (code 7) carries (start + i) mod 1024 on beat i. It never raises `last_beat`, and it runs until stopped or replaced.
- R7: Code 7 together with `cmd_intlv`=1 runs a sequential full-page burst.
- R8: The reserved length codes 4, 5 and 6 run a single-beat burst.
- R9: A stop sampled during a burst, without a start, makes `col_valid` 0 on the next cycle. A stop while idle has no effect.
- R10: A start during a burst restarts from the new column at beat 0 on the next cycle. This holds even if a stop is sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start or replace a burst |
| cmd_col | input | COL_W | Starting column |
| cmd_len | input | LEN_W | Burst length code |
| cmd_intlv | input | 1 | 1 = interleaved ordering, 0 = sequential |
| cmd_stop | input | 1 | Terminate the burst in progress |
| col_valid | output | 1 | A burst beat is presented |
| col_addr | output | COL_W | Column address of the current beat |
| last_beat | output | 1 | Final beat of a finite burst |

## Verification
The bench builds the block with its default parameters: a 10-bit column and a 3-bit length code. With these values a full-page burst wraps after 1024 beats, so the bench can run one past the top column and check the return to column zero. Every length code, including the reserved ones, can be reached from the 3-bit field. This brings the aligned-block wrap at the top of the column space and the reserved-code fallback within reach of short directed runs.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_e;

    localparam logic [2:0] LEN_ONE   = 3'd0;
    localparam logic [2:0] LEN_TWO   = 3'd1;
    localparam logic [2:0] LEN_FOUR  = 3'd2;
    localparam logic [2:0] LEN_EIGHT = 3'd3;
    localparam logic [2:0] LEN_PAGE  = 3'd7;

endpackage

// File: rtl/col_len_decode.sv
module col_len_decode #(
    parameter int COL_W = 10,
    parameter int LEN_W = 3
) (
    input  logic [LEN_W-1:0] len_code,
    input  logic             intlv_req,
    output logic [COL_W-1:0] wrap_mask,
    output logic             page_mode,
    output logic             intlv_eff
);
    import col_seq_pkg::*;

    localparam logic [COL_W-1:0] ALL_ONES = '1;

    logic [2:0] code3;
    assign code3 = 3'(len_code);

    always_comb begin
        wrap_mask = '0;
        page_mode = 1'b0;
        unique case (code3)
            LEN_ONE:   wrap_mask = COL_W'(0);
            LEN_TWO:   wrap_mask = COL_W'(1);
            LEN_FOUR:  wrap_mask = COL_W'(3);
            LEN_EIGHT: wrap_mask = COL_W'(7);
            LEN_PAGE: begin
                wrap_mask = ALL_ONES;
                page_mode = 1'b1;
            end
            default:   wrap_mask = COL_W'(0);
        endcase
        intlv_eff = intlv_req & ~page_mode;
    end

endmodule

// File: rtl/col_beat_ctr.sv
module col_beat_ctr #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    output logic [COL_W-1:0] beat
);
    logic [COL_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (clear) begin
            beat_q <= '0;
        end else if (adv) begin
            beat_q <= beat_q + COL_W'(1);
        end
    end

    assign beat = beat_q;

endmodule

// File: rtl/col_addr_gen.sv
module col_addr_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             intlv,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] sum;
    assign sum = base + beat;

    for (genvar g = 0; g < COL_W; g++) begin : g_bit
        assign addr[g] = intlv ? (base[g] ^ (beat[g] & wrap_mask[g]))
                               : (wrap_mask[g] ? sum[g] : base[g]);
    end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
    parameter int COL_W = 10,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             cmd_intlv,
    input  logic             cmd_stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             last_beat
);
    import col_seq_pkg::*;

    localparam int HI_LSB = 3;

    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, mask_q;
    logic             intlv_q;
    logic [COL_W-1:0] mask_d;
    logic             page_d, intlv_d;
    logic [COL_W-1:0] beat;
    logic             final_beat;
    logic             adv;

    col_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W)) u_dec (
        .len_code  (cmd_len),
        .intlv_req (cmd_intlv),
        .wrap_mask (mask_d),
        .page_mode (page_d),
        .intlv_eff (intlv_d)
    );

    assign final_beat = (state_q == ST_BURST) && (beat == mask_q);
    assign adv        = (state_q != ST_IDLE) && !cmd_start && !cmd_stop && !final_beat;

    col_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cmd_start),
        .adv   (adv),
        .beat  (beat)
    );

    col_addr_gen #(.COL_W(COL_W)) u_addr (
        .base      (base_q),
        .beat      (beat),
        .wrap_mask (mask_q),
        .intlv     (intlv_q),
        .addr      (col_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = page_d ? ST_PAGE : ST_BURST;
            end
            ST_BURST: begin
                if (cmd_start)                   state_d = page_d ? ST_PAGE : ST_BURST;
                else if (cmd_stop || final_beat) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (cmd_start)     state_d = page_d ? ST_PAGE : ST_BURST;
                else if (cmd_stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and burst context capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            intlv_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd_start) begin
                base_q  <= cmd_col;
                mask_q  <= mask_d;
                intlv_q <= intlv_d;
            end
        end
    end

    // outputs
    always_comb begin
        col_valid = 1'b0;
        last_beat = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BURST: begin
                col_valid = 1'b1;
                last_beat = final_beat;
            end
            ST_PAGE:  col_valid = 1'b1;
            default:  ;
        endcase
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!col_valid && !last_beat));

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (col_valid && col_addr == $past(cmd_col)));

    assert_block_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !cmd_start && !cmd_stop && !last_beat)
        |=> (col_addr[COL_W-1:HI_LSB] == $past(col_addr[COL_W-1:HI_LSB])));

    assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_valid);

    assert_end_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !cmd_start) |=> !col_valid);

    assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !last_beat);

    assert_page_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !cmd_start && !cmd_stop)
        |=> (col_addr == $past(col_addr) + COL_W'(1)));

    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start) |=> !col_valid);

endmodule

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;
    localparam int COL_W = 10;
    localparam int LEN_W = 3;
    localparam int NVEC  = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_start = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic             cmd_intlv = 1'b0;
    logic             cmd_stop = 1'b0;
    logic             col_valid;
    logic [COL_W-1:0] col_addr;
    logic             last_beat;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sdram_col_seq #(.COL_W(COL_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_col(cmd_col),
        .cmd_len(cmd_len), .cmd_intlv(cmd_intlv), .cmd_stop(cmd_stop),
        .col_valid(col_valid), .col_addr(col_addr), .last_beat(last_beat)
    );

    // {col[10], len[3], intlv[1], beats[4], final_col[10]}
    localparam logic [27:0] VEC [NVEC] = '{
        {10'h005, 3'd2, 1'b0, 4'd4, 10'h004},
        {10'h005, 3'd2, 1'b1, 4'd4, 10'h006},
        {10'h3FE, 3'd3, 1'b0, 4'd8, 10'h3FD},
        {10'h0A3, 3'd3, 1'b1, 4'd8, 10'h0A4},
        {10'h123, 3'd0, 1'b0, 4'd1, 10'h123},
        {10'h123, 3'd1, 1'b0, 4'd2, 10'h122},
        {10'h2F1, 3'd1, 1'b1, 4'd2, 10'h2F0},
        {10'h040, 3'd5, 1'b0, 4'd1, 10'h040},
        {10'h1C7, 3'd6, 1'b1, 4'd1, 10'h1C7}
    };

    task automatic chk(input string req, input int got, input int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int len_mask(input int len);
        case (len)
            1: return 1;
            2: return 3;
            3: return 7;
            7: return 1023;
            default: return 0;
        endcase
    endfunction

    function automatic int model_addr(input int col, input int len, input int ord, input int i);
        int m;
        m = len_mask(len);
        if (len == 7) return (col + i) % 1024;
        if (ord != 0) return col ^ i;
        return (col & ~m & 1023) | ((col + i) & m);
    endfunction

    task automatic start_cmd(input int col, input int len, input int ord, input bit stp);
        cmd_col   = COL_W'(col);
        cmd_len   = LEN_W'(len);
        cmd_intlv = ord[0];
        cmd_start = 1'b1;
        cmd_stop  = stp;
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_stop  = 1'b0;
    endtask

    task automatic walk(input int col, input int len, input int ord, input int first, input int n, input string tag);
        int m;
        m = len_mask(len);
        for (int i = first; i < first + n; i++) begin
            chk({tag, " valid"}, int'(col_valid), 1);
            chk({tag, " addr"}, int'(col_addr), model_addr(col, len, ord, i));
            chk("R5 last", int'(last_beat), (len != 7 && i == m) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog all-reqs got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        string tag;
        int beats, len, ord, col, fin;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(col_valid), 0);
        chk("R1 last in reset", int'(last_beat), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 valid after reset", int'(col_valid), 0);
        chk("R1 last after reset", int'(last_beat), 0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            col   = int'(VEC[v][27:18]);
            len   = int'(VEC[v][17:15]);
            ord   = int'(VEC[v][14]);
            beats = int'(VEC[v][13:10]);
            fin   = int'(VEC[v][9:0]);
            if (len >= 4 && len <= 6) tag = "R8";
            else if (ord != 0)        tag = "R4";
            else                      tag = "R3";
            start_cmd(col, len, ord, 1'b0);
            chk("R2 first beat", int'(col_addr), col);
            for (int i = 0; i < beats; i++) begin
                chk({tag, " valid"}, int'(col_valid), 1);
                chk({tag, " addr"}, int'(col_addr), model_addr(col, len, ord, i));
                chk("R5 last", int'(last_beat), (i == beats - 1) ? 1 : 0);
                if (i == beats - 1) chk({tag, " final col"}, int'(col_addr), fin);
                @(negedge clk);
            end
            chk("R5 idle after last", int'(col_valid), 0);
        end

        // R6: full page wraps past column 1023
        start_cmd(10'h3FC, 7, 0, 1'b0);
        walk(10'h3FC, 7, 0, 0, 1030, "R6");
        chk("R6 still running", int'(col_valid), 1);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9 stop full page", int'(col_valid), 0);

        // R7: full page with interleave request runs sequentially
        start_cmd(10'h3FD, 7, 1, 1'b0);
        walk(10'h3FD, 7, 0, 0, 6, "R7");
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9 stop R7 burst", int'(col_valid), 0);

        // R9: stop mid finite burst, and stop while idle
        start_cmd(10'h010, 3, 0, 1'b0);
        walk(10'h010, 3, 0, 0, 3, "R9");
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9 stop mid burst", int'(col_valid), 0);
        chk("R9 no last after stop", int'(last_beat), 0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9 stop idle", int'(col_valid), 0);
        start_cmd(10'h2A0, 1, 0, 1'b0);
        walk(10'h2A0, 1, 0, 0, 2, "R9 start after idle stop");
        chk("R9 end", int'(col_valid), 0);

        // R10: replace burst at beat 2, with stop asserted at same time
        start_cmd(10'h0F0, 3, 1, 1'b0);
        walk(10'h0F0, 3, 1, 0, 2, "R10 first");
        start_cmd(10'h200, 2, 0, 1'b1);
        chk("R10 new col", int'(col_addr), 10'h200);
        walk(10'h200, 2, 0, 0, 4, "R10");
        chk("R10 end", int'(col_valid), 0);

        // R10: replace a full page with a finite burst
        start_cmd(10'h100, 7, 0, 1'b0);
        walk(10'h100, 7, 0, 0, 3, "R10 page");
        start_cmd(10'h307, 2, 1, 1'b0);
        walk(10'h307, 2, 1, 0, 4, "R10 repl");
        chk("R10 end repl", int'(col_valid), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule